// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor. It runs one machine cycle at a time, and each T-state lasts one clock. A requester selects one of five cycle kinds: opcode fetch, memory read, memory write, I/O read or I/O write. The requester also supplies a 16-bit address and, for writes, a data byte. The sequencer then walks the T-states of that cycle. It drives the upper address byte, a multiplexed low-address/data bus with an address latch strobe, three status lines and active-low read and write strobes.

At the end of the cycle the block returns the byte read from the bus and gives a one-clock completion pulse. An opcode fetch normally takes four T-states. A configuration input, sampled when the request is accepted, stretches it to six. All other kinds take three T-states. Instruction decode, wait states, interrupts and bus hold belong to other blocks.

Top module: `bus_cycle_seq`

## Requirements
- R1: A memory read, memory write, I/O read or I/O write cycle lasts exactly 3 T-states. The first T-state (T1) is the clock after the edge that accepts the request, and `done` is high in the clock after the last T-state.
- R2: An opcode fetch lasts 4 T-states when `fetch_long` is 0 at the accepting edge and 6 when it is 1. Changing `fetch_long` after acceptance has no effect on the cycle in progress.
- R3: `req_kind` codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Through every T-state of a cycle, {`io_m`,`s1`,`s0`} is 011 for a fetch, 010 for a memory read, 001 for a memory write, 110 for an I/O read and 101 for an I/O write.
- R4: In T1, `ale` is 1, `addr_hi` carries address bits 15:8, `ad_out` carries bits 7:0 and `ad_oe` is 1. `ale` is 0 in every other T-state.
- R5: In fetch and read cycles, `rd_n` is 0 in T2 and T3 only and `wr_n` stays 1. `ad_oe` is 0 in T2 and T3.
- R6: In write cycles, `wr_n` is 0 in T2 and T3 only and `rd_n` stays 1. In T2 and T3, `ad_oe` is 1 and `ad_out` carries the write byte.
- R7: In fetch and read cycles, `rdata` takes the value of `ad_in` at the clock edge that ends T3. It then holds that value until the next such capture.
- R8: In fetch T-states T4 to T6 there is no bus activity: `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `ale` is 0.
- R9: `done` is high for exactly one clock. While the block is idle, `req_ready` is 1, the status lines are 000, `addr_hi` is 0 and both strobes are 1. A request held valid through the `done` clock is accepted at that clock's end, so its T1 follows `done` directly.
- R10: `rst_n` low forces idle at once: `rd_n` and `wr_n` are 1, `ale` is 0, `done` is 0 and `rdata` is 0. Release takes effect two clocks after `rst_n` rises, and until then `req_ready` is 0.
- R11: A request with `req_kind` 5, 6 or 7 is ignored. No cycle starts, `ale` and `done` stay 0 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| fetch_long | input | 1 | Selects 6-T-state opcode fetch |
| req_ready | output | 1 | Idle and able to accept a request |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Multiplexed address/data output |
| ad_oe | output | 1 | Output enable for the multiplexed bus |
| ad_in | input | 8 | Multiplexed bus input |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Byte captured in the last read |
| done | output | 1 | One-clock cycle completion pulse |

## Verification
Each of the five cycle kinds is run with a distinct address and data byte, including all-zero and all-one addresses. Each run tells the kinds apart by their status code, their strobe, and which side drives the multiplexed bus. The bench offers the read byte on `ad_in` only during T3, so a capture one edge early or late returns the inverted byte. The short and long fetch are compared with `fetch_long` flipped right after acceptance, which separates a length sampled at the start from one read later. Directed runs cover back-to-back requests, ignored codes 5 to 7, and reset asserted in the middle of a write.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int TS_W = 3;
  localparam logic [TS_W-1:0] LEN_RW         = TS_W'(3);
  localparam logic [TS_W-1:0] LEN_FETCH      = TS_W'(4);
  localparam logic [TS_W-1:0] LEN_FETCH_LONG = TS_W'(6);
  localparam logic [TS_W-1:0] TS_IDLE        = '0;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  localparam status_t ST_IDLE = '0;

  function automatic logic kind_ok(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic is_write(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic status_t status_of(kind_e k);
    status_t s;
    case (k)
      K_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      K_MRD:   s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      K_MWR:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      K_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      K_IOWR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default: s = ST_IDLE;
    endcase
    return s;
  endfunction

  function automatic logic [TS_W-1:0] cycle_len(kind_e k, logic long_fetch);
    if (k == K_FETCH) return long_fetch ? LEN_FETCH_LONG : LEN_FETCH;
    return LEN_RW;
  endfunction

endpackage

// File: rtl/bcs_tctr.sv
module bcs_tctr
  import bcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TS_W-1:0] len_i,
  output logic [TS_W-1:0] tstate,
  output logic            idle,
  output logic            done
);

  logic [TS_W-1:0] ts_q, ts_d;
  logic [TS_W-1:0] len_q, len_d;
  logic            done_q, done_d;
  logic            adv_en;

  always_comb begin
    ts_d   = ts_q;
    len_d  = len_q;
    done_d = 1'b0;
    if (ts_q == TS_IDLE) begin
      if (start) begin
        ts_d  = TS_W'(1);
        len_d = len_i;
      end
    end else if (ts_q == len_q) begin
      ts_d   = TS_IDLE;
      done_d = 1'b1;
    end else begin
      ts_d = ts_q + TS_W'(1);
    end
  end

  assign adv_en = start | (ts_q != TS_IDLE) | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= TS_IDLE;
      len_q  <= LEN_RW;
      done_q <= 1'b0;
    end else if (adv_en) begin
      ts_q   <= ts_d;
      len_q  <= len_d;
      done_q <= done_d;
    end
  end

  assign tstate = ts_q;
  assign idle   = (ts_q == TS_IDLE);
  assign done   = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_start_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> (ts_q == TS_W'(1)));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ts_q == TS_IDLE));

endmodule

// File: rtl/bcs_req_latch.sv
module bcs_req_latch
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      kind_q  <= kind_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

endmodule

// File: rtl/bcs_bus_drv.sv
module bcs_bus_drv
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          tstate,
  input  kind_e                    kind,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic                     ale,
  output status_t                  status,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        rdata
);

  logic active, in_t1, in_strobe, wr_kind, cap_en;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    active    = (tstate != TS_IDLE);
    in_t1     = (tstate == TS_W'(1));
    in_strobe = (tstate == TS_W'(2)) || (tstate == TS_W'(3));
    wr_kind   = is_write(kind);
    cap_en    = (tstate == TS_W'(3)) && !wr_kind;

    status  = active ? status_of(kind) : ST_IDLE;
    addr_hi = active ? addr[ADDR_W-1:DATA_W] : '0;
    ale     = in_t1;
    ad_oe   = in_t1 | (in_strobe & wr_kind);
    if (in_t1)                    ad_out = addr[DATA_W-1:0];
    else if (in_strobe & wr_kind) ad_out = wdata;
    else                          ad_out = '0;
    rd_n = !(in_strobe & !wr_kind);
    wr_n = !(in_strobe &  wr_kind);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  assign rdata = rdata_q;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_rd_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_wr_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != TS_W'(3)) |=> $stable(rdata_q));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     fetch_long,
  output logic                     req_ready,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   srst_n;
  logic                   start, idle;
  logic [TS_W-1:0]        tstate, len_req;
  kind_e                  kind_in, kind_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      wdata_q;
  status_t                status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rsync_q[SYNC_STAGES-1];

  assign kind_in   = kind_e'(req_kind);
  assign req_ready = srst_n & idle;
  assign start     = req_valid & req_ready & kind_ok(req_kind);
  assign len_req   = cycle_len(kind_in, fetch_long);

  bcs_tctr u_tctr (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start),
    .len_i  (len_req),
    .tstate (tstate),
    .idle   (idle),
    .done   (done)
  );

  bcs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (start),
    .kind_i  (kind_in),
    .addr_i  (req_addr),
    .wdata_i (req_wdata),
    .kind_o  (kind_q),
    .addr_o  (addr_q),
    .wdata_o (wdata_q)
  );

  bcs_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk     (clk),
    .rst_n   (srst_n),
    .tstate  (tstate),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .ad_in   (ad_in),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .status  (status),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rdata   (rdata)
  );

  assign io_m = status.io_m;
  assign s1   = status.s1;
  assign s0   = status.s0;

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!srst_n)
    req_ready |-> ({io_m, s1, s0} == 3'b000 && rd_n && wr_n && !ale));

  assert_bad_kind_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && !kind_ok(req_kind)) |=> req_ready);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> req_ready);

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic       fetch_long;
  logic       req_ready;
  logic [7:0] addr_hi;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [7:0] ad_in;
  logic       ale, io_m, s1, s0, rd_n, wr_n, done;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .fetch_long(fetch_long),
    .req_ready(req_ready), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .done(done)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic        lng;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rbyte;
    logic [2:0]  elen;
    logic [2:0]  est;
    logic        erd;
    logic        ewr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 16'h2000, 8'h00, 8'h3E, 3'd4, 3'b011, 1'b1, 1'b0},
    '{3'd1, 1'b0, 16'h2001, 8'h00, 8'h32, 3'd3, 3'b010, 1'b1, 1'b0},
    '{3'd2, 1'b0, 16'h4A5C, 8'hA7, 8'h00, 3'd3, 3'b001, 1'b0, 1'b1},
    '{3'd3, 1'b0, 16'h0081, 8'h00, 8'hC4, 3'd3, 3'b110, 1'b1, 1'b0},
    '{3'd4, 1'b1, 16'h00FE, 8'h5B, 8'h00, 3'd3, 3'b101, 1'b0, 1'b1},
    '{3'd0, 1'b1, 16'hFFFF, 8'h00, 8'h76, 3'd6, 3'b011, 1'b1, 1'b0},
    '{3'd1, 1'b1, 16'h0000, 8'h00, 8'hFF, 3'd3, 3'b010, 1'b1, 1'b0},
    '{3'd2, 1'b0, 16'hFFFF, 8'h00, 8'h00, 3'd3, 3'b001, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(1'b0, "WDOG", "watchdog expired", cycles, 20000);
      finish_run();
    end
  end

  task automatic wait_ready();
    for (int i = 0; i < 20 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int  n;
    bit  seen_done;
    wait_ready();
    req_valid  = 1'b1;
    req_kind   = v.kind;
    fetch_long = v.lng;
    req_addr   = v.addr;
    req_wdata  = v.wdata;
    ad_in      = ~v.rbyte;
    @(negedge clk);
    req_valid  = 1'b0;
    fetch_long = ~v.lng;   // R2: late change must not matter
    n = 0;
    seen_done = 1'b0;
    while (!seen_done && n < 10) begin
      if (done) begin
        seen_done = 1'b1;
      end else begin
        n++;
        chk({io_m, s1, s0} == v.est, "R3", $sformatf("v%0d T%0d status", idx, n),
            {io_m, s1, s0}, v.est);
        if (n == 1) begin
          chk(ale && ad_oe && ad_out == v.addr[7:0] && addr_hi == v.addr[15:8], "R4",
              $sformatf("v%0d T1 ale/oe/addr", idx), {ale, ad_oe, addr_hi, ad_out},
              {2'b11, v.addr});
        end else begin
          chk(!ale, "R4", $sformatf("v%0d T%0d ale low", idx, n), ale, 0);
        end
        if (n == 2 || n == 3) begin
          if (v.ewr)
            chk(!wr_n && rd_n && ad_oe && ad_out == v.wdata, "R6",
                $sformatf("v%0d T%0d write strobe/data", idx, n),
                {rd_n, wr_n, ad_oe, ad_out}, {3'b101, v.wdata});
          else
            chk(!rd_n && wr_n && !ad_oe, "R5",
                $sformatf("v%0d T%0d read strobe", idx, n), {rd_n, wr_n, ad_oe}, 3'b010);
        end
        if (n >= 4)
          chk(rd_n && wr_n && !ad_oe, "R8", $sformatf("v%0d T%0d quiet", idx, n),
              {rd_n, wr_n, ad_oe}, 3'b110);
        if (n == 3) ad_in = v.rbyte;
        else        ad_in = ~v.rbyte;
        @(negedge clk);
      end
    end
    ad_in = ~v.rbyte;
    chk(n == int'(v.elen), (v.kind == 3'd0) ? "R2" : "R1",
        $sformatf("v%0d T-state count", idx), n, v.elen);
    chk(req_ready && {io_m, s1, s0} == 3'b000 && addr_hi == 8'h00 && rd_n && wr_n, "R9",
        $sformatf("v%0d idle at done", idx), {req_ready, io_m, s1, s0, rd_n, wr_n}, 6'b100011);
    if (v.erd)
      chk(rdata == v.rbyte, "R7", $sformatf("v%0d captured byte", idx), rdata, v.rbyte);
    @(negedge clk);
    chk(!done, "R9", $sformatf("v%0d done single clock", idx), done, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
    req_wdata = '0; fetch_long = 1'b0; ad_in = 8'h00;
    repeat (4) @(negedge clk);
    chk(rd_n && wr_n && !ale && !done && rdata == 8'h00 && !req_ready, "R10",
        "in reset", {rd_n, wr_n, ale, done, req_ready, rdata}, {5'b11000, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10", "ready held during release", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(req_ready && {io_m, s1, s0} == 3'b000, "R10", "idle after release",
        {req_ready, io_m, s1, s0}, 4'b1000);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R11: unsupported kind codes
    for (int k = 5; k < 8; k++) begin
      wait_ready();
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      for (int j = 0; j < 3; j++) begin
        chk(req_ready && !ale && !done && rd_n && wr_n, "R11",
            $sformatf("kind %0d ignored", k), {req_ready, ale, done}, 3'b100);
        @(negedge clk);
      end
    end

    // R9: back-to-back requests with valid held
    wait_ready();
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h3344; ad_in = 8'h11;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done, "R9", "first done", done, 1);
    req_addr = 16'h5566;
    @(negedge clk);
    chk(ale && ad_out == 8'h66 && addr_hi == 8'h55, "R9", "next T1 right after done",
        {ale, addr_hi, ad_out}, {1'b1, 16'h5566});
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done, "R9", "second done", done, 1);

    // R10: reset in the middle of a write
    @(negedge clk);
    wait_ready();
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h7788; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!wr_n, "R6", "write strobe before reset", wr_n, 0);
    rst_n = 1'b0;
    #1;
    chk(wr_n && rd_n && !ale && !done && {io_m, s1, s0} == 3'b000 && rdata == 8'h00, "R10",
        "mid-cycle reset idles bus", {wr_n, rd_n, ale, done, io_m, s1, s0, rdata},
        {7'b1100000, 8'h00});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !done, "R10", "ready after mid reset", {req_ready, done}, 2'b10);

    finish_run();
  end

endmodule